// File: doc/BRIEF.md
# Floating-Point Macro-Op Issue Scheduler

This block sits between the rename stage and the floating-point execution units. On every clock it takes up to three macro-ops, one per dispatch lane, and writes each into the issue queue that belongs to that lane. Each entry waits until its source operands are available. Operands become available when a producing result appears on one of the execution result buses, or when a load returns its data. A load return is bypassed straight into issue selection, so a dependent operation can leave the queue in the same cycle that the load data arrives. Each queue then sends its oldest ready entry to the execution units.

A mispredicted branch triggers a flush that carries an age boundary. Every queued, issuing, arriving or completing operation that is younger than that boundary is discarded. Completions seen on the result buses are passed on, one cycle later, to the retire logic as completion notices.

Ages are modular counters. An age `a` is younger than an age `b` when `a != b` and `(a - b) mod 2^AW` is below `2^(AW-1)`.

Top module: `fp_mop_sched`

## Requirements
- R1: While reset is high, and on the first cycle after it, `iss_valid` and `ret_valid` are all zero, and `in_ready` is high once every queue is empty.
- R2: When `in_ready` is high, every lane whose `in_valid` bit is set is written into its own queue in that cycle, with any mix of unit classes (0 add, 1 multiply, 2 store). An entry with no pending source shows on that lane's issue outputs after the second rising edge, counting the edge that accepted it.
- R3: Each queue issues at most one entry per cycle. Among its ready entries, it picks the one with the oldest age.
- R4: A result-bus broadcast of a tag marks matching pending sources ready at that edge. The entry can then issue, and it appears on the issue outputs after the following edge.
- R5: When `ld_valid` is high, an entry whose last pending source matches `ld_tag` can be selected in that same cycle. It appears on the issue outputs after that edge with `iss_fwd` set. `iss_fwd` is clear for entries that were already fully ready.
- R6: A source that is being broadcast on a result bus, or returned as a load, in the same cycle that its entry is written is stored as ready, so it never waits for that tag again.
- R7: Each queue holds DEPTH (14) entries, 42 in total. `in_ready` is low while any queue is full, and ops offered while it is low are not taken.
- R8: When `flush_valid` is high, entries younger than `flush_age` are removed. An entry chosen for issue in that cycle that is younger than the boundary is not reported. Incoming ops younger than the boundary are not written. Entries at or older than the boundary stay.
- R9: For each result bus, `ret_valid`/`ret_tag` repeat `res_valid`/`res_tag` one cycle later. The notice is dropped if a flush in the same cycle has a boundary older than `res_age`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NQ | Per-lane macro-op offer |
| in_age | input | NQ*AW | Per-lane age tag |
| in_cls | input | NQ*2 | Per-lane unit class |
| in_src0 | input | NQ*TW | First source physical tag |
| in_wait0 | input | NQ | First source still pending |
| in_src1 | input | NQ*TW | Second source physical tag |
| in_wait1 | input | NQ | Second source still pending |
| in_dst | input | NQ*TW | Destination physical tag |
| in_ready | output | 1 | All lanes can take an op |
| res_valid | input | NRB | Result bus broadcast valid |
| res_tag | input | NRB*TW | Result bus destination tag |
| res_age | input | NRB*AW | Age of the completing op |
| ld_valid | input | 1 | Load data returning |
| ld_tag | input | TW | Tag the load writes |
| flush_valid | input | 1 | Mispredict nulling command |
| flush_age | input | AW | Age boundary of the flush |
| iss_valid | output | NQ | Per-queue issue |
| iss_dst | output | NQ*TW | Issued destination tag |
| iss_age | output | NQ*AW | Issued age |
| iss_cls | output | NQ*2 | Issued unit class |
| iss_fwd | output | NQ | Issue used the load bypass |
| ret_valid | output | NRB | Completion notice valid |
| ret_tag | output | NRB*TW | Completed destination tag |

## Verification
The assertions assume three things about the inputs: every live age is unique, ages within one lane increase in order of arrival, and all outstanding ages lie within half of the modular age range, so age comparisons are well defined. The stimulus takes ages from a single counter that advances once per offered op. It draws pending sources from a small tag set that the result buses and the load return broadcast often, so entries drain long before the counter could wrap past them. Offers made while `in_ready` is low are still driven, to show that the block drops them. Flush boundaries are always taken from recent ages.

// File: rtl/fpsq_pkg.sv
package fpsq_pkg;
  localparam int CLS_W = 2;
  typedef enum logic [CLS_W-1:0] {
    UNIT_ADD = 2'd0,
    UNIT_MUL = 2'd1,
    UNIT_STO = 2'd2
  } unit_cls_t;
endpackage

// File: rtl/fpsq_oldest.sv
module fpsq_oldest #(
  parameter int N  = 14,
  parameter int AW = 8,
  parameter int IW = 4
) (
  input  logic [N-1:0]    req,
  input  logic [N*AW-1:0] age_flat,
  output logic            found,
  output logic [IW-1:0]   idx
);
  function automatic logic is_younger(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return (d != '0) && !d[AW-1];
  endfunction

  logic [AW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || is_younger(best, age_flat[i*AW +: AW]))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = age_flat[i*AW +: AW];
      end
    end
  end
endmodule

// File: rtl/fpsq_queue.sv
module fpsq_queue
  import fpsq_pkg::*;
#(
  parameter int DEPTH = 14,
  parameter int TW    = 7,
  parameter int AW    = 8,
  parameter int NRB   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [AW-1:0]     a_age,
  input  logic [CLS_W-1:0]  a_cls,
  input  logic [TW-1:0]     a_src0,
  input  logic              a_wait0,
  input  logic [TW-1:0]     a_src1,
  input  logic              a_wait1,
  input  logic [TW-1:0]     a_dst,
  input  logic [NRB-1:0]    res_valid,
  input  logic [NRB*TW-1:0] res_tag,
  input  logic              ld_valid,
  input  logic [TW-1:0]     ld_tag,
  input  logic              flush_valid,
  input  logic [AW-1:0]     flush_age,
  output logic              has_room,
  output logic              iss_valid,
  output logic [TW-1:0]     iss_dst,
  output logic [AW-1:0]     iss_age,
  output logic [CLS_W-1:0]  iss_cls,
  output logic              iss_fwd
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic is_younger(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return (d != '0) && !d[AW-1];
  endfunction

  function automatic logic bus_hit(input logic [TW-1:0] t, input logic [NRB-1:0] v,
                                   input logic [NRB*TW-1:0] tags);
    logic h;
    h = 1'b0;
    for (int b = 0; b < NRB; b++) h = h | (v[b] && tags[b*TW +: TW] == t);
    return h;
  endfunction

  logic [DEPTH-1:0]    vld, rdy0, rdy1;
  logic [AW-1:0]       e_age  [DEPTH];
  logic [CLS_W-1:0]    e_cls  [DEPTH];
  logic [TW-1:0]       e_src0 [DEPTH];
  logic [TW-1:0]       e_src1 [DEPTH];
  logic [TW-1:0]       e_dst  [DEPTH];

  logic [DEPTH-1:0]    ld0, ld1, bus0, bus1, req, kill;
  logic [DEPTH*AW-1:0] age_flat;
  logic [IW-1:0]       free_idx, pick_idx;
  logic                pick_vld, pick_killed, a_rdy0, a_rdy1;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      ld0[i]  = ld_valid && (ld_tag == e_src0[i]);
      ld1[i]  = ld_valid && (ld_tag == e_src1[i]);
      bus0[i] = bus_hit(e_src0[i], res_valid, res_tag);
      bus1[i] = bus_hit(e_src1[i], res_valid, res_tag);
      req[i]  = vld[i] && (rdy0[i] || ld0[i]) && (rdy1[i] || ld1[i]);
      kill[i] = flush_valid && is_younger(e_age[i], flush_age);
      age_flat[i*AW +: AW] = e_age[i];
      if (!vld[i]) free_idx = IW'(i);
    end
    has_room    = ~&vld;
    pick_killed = flush_valid && is_younger(e_age[pick_idx], flush_age);
    a_rdy0 = !a_wait0 || bus_hit(a_src0, res_valid, res_tag) || (ld_valid && ld_tag == a_src0);
    a_rdy1 = !a_wait1 || bus_hit(a_src1, res_valid, res_tag) || (ld_valid && ld_tag == a_src1);
  end

  fpsq_oldest #(.N(DEPTH), .AW(AW), .IW(IW)) u_pick (
    .req      (req),
    .age_flat (age_flat),
    .found    (pick_vld),
    .idx      (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld       <= '0;
      iss_valid <= 1'b0;
      iss_fwd   <= 1'b0;
      iss_dst   <= '0;
      iss_age   <= '0;
      iss_cls   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        rdy0[i] <= rdy0[i] | ld0[i] | bus0[i];
        rdy1[i] <= rdy1[i] | ld1[i] | bus1[i];
        if ((pick_vld && pick_idx == IW'(i)) || kill[i]) vld[i] <= 1'b0;
      end
      if (alloc) begin
        vld[free_idx]    <= 1'b1;
        e_age[free_idx]  <= a_age;
        e_cls[free_idx]  <= a_cls;
        e_src0[free_idx] <= a_src0;
        e_src1[free_idx] <= a_src1;
        e_dst[free_idx]  <= a_dst;
        rdy0[free_idx]   <= a_rdy0;
        rdy1[free_idx]   <= a_rdy1;
      end
      iss_valid <= pick_vld && !pick_killed;
      iss_fwd   <= pick_vld && !pick_killed && !(rdy0[pick_idx] && rdy1[pick_idx]);
      iss_dst   <= e_dst[pick_idx];
      iss_age   <= e_age[pick_idx];
      iss_cls   <= e_cls[pick_idx];
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    alloc |-> has_room);

  // R5
  fwd_source_chk: assert property (@(posedge clk) disable iff (rst)
    iss_fwd |-> (iss_valid && $past(ld_valid)));

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      // R8
      flush_kill_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && vld[g] && is_younger(e_age[g], flush_age)) |=> !vld[g]);
    end
  endgenerate
endmodule

// File: rtl/fp_mop_sched.sv
module fp_mop_sched
  import fpsq_pkg::*;
#(
  parameter int NQ    = 3,
  parameter int DEPTH = 14,
  parameter int TW    = 7,
  parameter int AW    = 8,
  parameter int NRB   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ-1:0]       in_valid,
  input  logic [NQ*AW-1:0]    in_age,
  input  logic [NQ*CLS_W-1:0] in_cls,
  input  logic [NQ*TW-1:0]    in_src0,
  input  logic [NQ-1:0]       in_wait0,
  input  logic [NQ*TW-1:0]    in_src1,
  input  logic [NQ-1:0]       in_wait1,
  input  logic [NQ*TW-1:0]    in_dst,
  output logic                in_ready,
  input  logic [NRB-1:0]      res_valid,
  input  logic [NRB*TW-1:0]   res_tag,
  input  logic [NRB*AW-1:0]   res_age,
  input  logic                ld_valid,
  input  logic [TW-1:0]       ld_tag,
  input  logic                flush_valid,
  input  logic [AW-1:0]       flush_age,
  output logic [NQ-1:0]       iss_valid,
  output logic [NQ*TW-1:0]    iss_dst,
  output logic [NQ*AW-1:0]    iss_age,
  output logic [NQ*CLS_W-1:0] iss_cls,
  output logic [NQ-1:0]       iss_fwd,
  output logic [NRB-1:0]      ret_valid,
  output logic [NRB*TW-1:0]   ret_tag
);
  function automatic logic is_younger(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return (d != '0) && !d[AW-1];
  endfunction

  logic [NQ-1:0] room, accept;

  always_comb begin
    in_ready = &room;
    for (int q = 0; q < NQ; q++)
      accept[q] = in_valid[q] && in_ready &&
                  !(flush_valid && is_younger(in_age[q*AW +: AW], flush_age));
  end

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_q
      fpsq_queue #(.DEPTH(DEPTH), .TW(TW), .AW(AW), .NRB(NRB)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .alloc       (accept[q]),
        .a_age       (in_age[q*AW +: AW]),
        .a_cls       (in_cls[q*CLS_W +: CLS_W]),
        .a_src0      (in_src0[q*TW +: TW]),
        .a_wait0     (in_wait0[q]),
        .a_src1      (in_src1[q*TW +: TW]),
        .a_wait1     (in_wait1[q]),
        .a_dst       (in_dst[q*TW +: TW]),
        .res_valid   (res_valid),
        .res_tag     (res_tag),
        .ld_valid    (ld_valid),
        .ld_tag      (ld_tag),
        .flush_valid (flush_valid),
        .flush_age   (flush_age),
        .has_room    (room[q]),
        .iss_valid   (iss_valid[q]),
        .iss_dst     (iss_dst[q*TW +: TW]),
        .iss_age     (iss_age[q*AW +: AW]),
        .iss_cls     (iss_cls[q*CLS_W +: CLS_W]),
        .iss_fwd     (iss_fwd[q])
      );
    end

    for (genvar b = 0; b < NRB; b++) begin : g_ret
      always_ff @(posedge clk) begin
        if (rst) begin
          ret_valid[b] <= 1'b0;
          ret_tag[b*TW +: TW] <= '0;
        end else begin
          ret_valid[b] <= res_valid[b] &&
                          !(flush_valid && is_younger(res_age[b*AW +: AW], flush_age));
          ret_tag[b*TW +: TW] <= res_tag[b*TW +: TW];
        end
      end

      // R9
      ret_source_chk: assert property (@(posedge clk) disable iff (rst)
        ret_valid[b] |-> $past(res_valid[b]));

      // R9
      ret_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid[b] && !flush_valid) |=> ret_valid[b]);
    end
  endgenerate

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (iss_valid == '0 && ret_valid == '0));
endmodule

// File: tb/fp_mop_sched_test.sv
`timescale 1ns/1ps
module fp_mop_sched_test;
  import fpsq_pkg::*;
  localparam int NQ = 3, DEPTH = 14, TW = 7, AW = 10, NRB = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NQ-1:0] in_valid, in_wait0, in_wait1, iss_valid, iss_fwd;
  logic [NQ*AW-1:0] in_age, iss_age;
  logic [NQ*2-1:0] in_cls, iss_cls;
  logic [NQ*TW-1:0] in_src0, in_src1, in_dst, iss_dst;
  logic in_ready, ld_valid, flush_valid;
  logic [NRB-1:0] res_valid, ret_valid;
  logic [NRB*TW-1:0] res_tag, ret_tag;
  logic [NRB*AW-1:0] res_age;
  logic [TW-1:0] ld_tag;
  logic [AW-1:0] flush_age;

  int nchk = 0, nerr = 0, age_ctr = 1;

  always #2 clk = ~clk;

  fp_mop_sched #(.NQ(NQ), .DEPTH(DEPTH), .TW(TW), .AW(AW), .NRB(NRB)) uut (.*);

  // bench reference state
  bit mv [NQ][DEPTH];
  bit mr0 [NQ][DEPTH];
  bit mr1 [NQ][DEPTH];
  logic [AW-1:0] mage [NQ][DEPTH];
  logic [TW-1:0] mdst [NQ][DEPTH];
  logic [TW-1:0] ms0 [NQ][DEPTH];
  logic [TW-1:0] ms1 [NQ][DEPTH];
  logic [1:0] mcls [NQ][DEPTH];
  bit e_iv [NQ];
  bit e_fwd [NQ];
  logic [TW-1:0] e_dst [NQ];
  logic [AW-1:0] e_age [NQ];
  logic [1:0] e_cls [NQ];
  bit e_rv [NRB];
  logic [TW-1:0] e_rt [NRB];
  bit e_rdy;

  function automatic bit yng(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return (d != 0) && !d[AW-1];
  endfunction

  function automatic bit hit(input logic [TW-1:0] t);
    bit h = ld_valid && ld_tag == t;
    for (int b = 0; b < NRB; b++) if (res_valid[b] && res_tag[b*TW +: TW] == t) h = 1;
    return h;
  endfunction

  function automatic bit all_room();
    for (int q = 0; q < NQ; q++) begin
      int c = 0;
      for (int i = 0; i < DEPTH; i++) c += mv[q][i];
      if (c >= DEPTH) return 0;
    end
    return 1;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_eval();
    bit rdy_pre = all_room();
    for (int q = 0; q < NQ; q++) begin
      int best = -1;
      for (int i = 0; i < DEPTH; i++)
        if (mv[q][i] && (mr0[q][i] || (ld_valid && ms0[q][i] == ld_tag)) &&
            (mr1[q][i] || (ld_valid && ms1[q][i] == ld_tag)))
          if (best < 0 || yng(mage[q][best], mage[q][i])) best = i;
      e_iv[q] = 0; e_fwd[q] = 0;
      if (best >= 0) begin
        e_iv[q]  = !(flush_valid && yng(mage[q][best], flush_age));
        e_fwd[q] = e_iv[q] && !(mr0[q][best] && mr1[q][best]);
        e_dst[q] = mdst[q][best]; e_age[q] = mage[q][best]; e_cls[q] = mcls[q][best];
        mv[q][best] = 0;
      end
      for (int i = 0; i < DEPTH; i++) if (mv[q][i]) begin
        if (flush_valid && yng(mage[q][i], flush_age)) mv[q][i] = 0;
        if (hit(ms0[q][i])) mr0[q][i] = 1;
        if (hit(ms1[q][i])) mr1[q][i] = 1;
      end
      if (in_valid[q] && rdy_pre && !(flush_valid && yng(in_age[q*AW +: AW], flush_age)))
        for (int i = 0; i < DEPTH; i++) if (!mv[q][i]) begin
          mv[q][i] = 1; mage[q][i] = in_age[q*AW +: AW]; mdst[q][i] = in_dst[q*TW +: TW];
          mcls[q][i] = in_cls[q*2 +: 2];
          ms0[q][i] = in_src0[q*TW +: TW]; ms1[q][i] = in_src1[q*TW +: TW];
          mr0[q][i] = !in_wait0[q] || hit(in_src0[q*TW +: TW]);
          mr1[q][i] = !in_wait1[q] || hit(in_src1[q*TW +: TW]);
          break;
        end
    end
    for (int b = 0; b < NRB; b++) begin
      e_rv[b] = res_valid[b] && !(flush_valid && yng(res_age[b*AW +: AW], flush_age));
      e_rt[b] = res_tag[b*TW +: TW];
    end
    e_rdy = all_room();
  endtask

  task automatic idle();
    in_valid = 0; in_wait0 = 0; in_wait1 = 0; in_age = 0; in_cls = 0;
    in_src0 = 0; in_src1 = 0; in_dst = 0;
    res_valid = 0; res_tag = 0; res_age = 0; ld_valid = 0; ld_tag = 0;
    flush_valid = 0; flush_age = 0;
  endtask

  task automatic offer(input int q, input int dst, input bit w0, input int s0,
                       input bit w1, input int s1);
    unit_cls_t c = unit_cls_t'($urandom_range(0, 2));
    in_valid[q] = 1;
    in_age[q*AW +: AW] = AW'(age_ctr); age_ctr++;
    in_cls[q*2 +: 2] = c;
    in_dst[q*TW +: TW] = TW'(dst);
    in_wait0[q] = w0; in_src0[q*TW +: TW] = TW'(s0);
    in_wait1[q] = w1; in_src1[q*TW +: TW] = TW'(s1);
  endtask

  task automatic bcast(input int b, input int tag, input int age);
    res_valid[b] = 1; res_tag[b*TW +: TW] = TW'(tag); res_age[b*AW +: AW] = AW'(age);
  endtask

  task automatic step(input string tag);
    model_eval();
    @(posedge clk); #1;
    for (int q = 0; q < NQ; q++) begin
      chk(tag, $sformatf("iss_valid[%0d]", q), iss_valid[q], e_iv[q]);
      if (e_iv[q]) begin
        chk(tag, $sformatf("iss_dst[%0d]", q), iss_dst[q*TW +: TW], e_dst[q]);
        chk(tag, $sformatf("iss_age[%0d]", q), iss_age[q*AW +: AW], e_age[q]);
        chk(tag, $sformatf("iss_cls[%0d]", q), iss_cls[q*2 +: 2], e_cls[q]);
        chk(tag, $sformatf("iss_fwd[%0d]", q), iss_fwd[q], e_fwd[q]);
      end
    end
    for (int b = 0; b < NRB; b++) begin
      chk(tag, $sformatf("ret_valid[%0d]", b), ret_valid[b], e_rv[b]);
      if (e_rv[b]) chk(tag, $sformatf("ret_tag[%0d]", b), ret_tag[b*TW +: TW], e_rt[b]);
    end
    chk(tag, "in_ready", in_ready, e_rdy);
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    void'($urandom(32'h5eed_1234));
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", "iss_valid", iss_valid, 0);
    chk("R1", "ret_valid", ret_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    @(negedge clk);

    // R2 three lanes, mixed classes, issue after two edges
    for (int q = 0; q < NQ; q++) offer(q, 40 + q, 0, 0, 0, 0);
    step("R2"); step("R2"); step("R2");

    // R3 older waiting entry beats younger ready ones after it wakes
    offer(0, 50, 1, 5, 0, 0); step("R3");
    offer(0, 51, 0, 0, 0, 0); step("R3");
    offer(0, 52, 0, 0, 0, 0); bcast(0, 5, 0); step("R3");
    step("R3"); step("R3"); step("R3");

    // R4 result bus wakeup
    offer(1, 60, 1, 9, 1, 9); step("R4");
    step("R4"); step("R4");
    bcast(1, 9, 0); step("R4"); step("R4"); step("R4");

    // R5 load bypass issues in the load's own cycle
    offer(2, 70, 1, 11, 0, 0); step("R5"); step("R5");
    ld_valid = 1; ld_tag = 11; step("R5"); step("R5");

    // R6 wakeup in the same cycle as allocation
    offer(0, 80, 1, 12, 0, 0); bcast(0, 12, 0);
    offer(1, 81, 0, 0, 1, 13); ld_valid = 1; ld_tag = 13;
    step("R6"); step("R6"); step("R6");

    // R7 fill one queue, stall, drop offer, drain
    for (int i = 0; i < DEPTH; i++) begin offer(0, 90 + i, 1, 20, 0, 0); step("R7"); end
    offer(0, 127, 0, 0, 0, 0); offer(1, 126, 0, 0, 0, 0); step("R7");
    bcast(0, 20, 0); step("R7");
    for (int i = 0; i < DEPTH + 2; i++) step("R7");

    // R8 flush with age boundary
    base = age_ctr;
    for (int i = 0; i < 4; i++) begin offer(1, 100 + i, 1, 30, 0, 0); step("R8"); end
    offer(2, 110, 0, 0, 0, 0); step("R8");
    flush_valid = 1; flush_age = AW'(base + 1);
    offer(0, 111, 0, 0, 0, 0);
    step("R8");
    flush_valid = 1; flush_age = AW'(base);
    bcast(0, 30, 0); step("R8");
    for (int i = 0; i < 4; i++) step("R8");

    // R9 completion notices, with and without suppression
    bcast(0, 33, age_ctr); bcast(1, 34, age_ctr - 3); step("R9");
    flush_valid = 1; flush_age = AW'(age_ctr - 2);
    bcast(0, 35, age_ctr - 1); bcast(1, 36, age_ctr - 4); step("R9");
    step("R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      if (in_ready)
        for (int q = 0; q < NQ; q++)
          if ($urandom_range(0, 99) < 45)
            offer(q, $urandom_range(0, 127), $urandom_range(0, 1), $urandom_range(0, 15),
                  $urandom_range(0, 1), $urandom_range(0, 15));
      for (int b = 0; b < NRB; b++)
        if ($urandom_range(0, 99) < 50) bcast(b, $urandom_range(0, 15), age_ctr - $urandom_range(1, 20));
      if ($urandom_range(0, 99) < 30) begin ld_valid = 1; ld_tag = TW'($urandom_range(0, 15)); end
      if ($urandom_range(0, 99) < 2) begin flush_valid = 1; flush_age = AW'(age_ctr - $urandom_range(0, 10)); end
      step("R2/R3/R4/R5/R6/R8");
    end
    finish_run();
  end
endmodule